// File: doc/BRIEF.md
# Receive Character Buffer with Per-Byte Error Tags

This block holds characters delivered by a serial receiver front end until the host collects them. Each byte enters the buffer together with three error tags: parity error, framing error and break. The tags move through the queue with their byte. They reach the host-visible line status only when that byte becomes the oldest entry. A host that reads status first and then pops data therefore sees the errors that belong to the byte it is about to take.

A character that arrives while the buffer is full is thrown away, and an overrun status bit records the loss. The host takes the oldest byte with a data-read strobe and samples the status vector with a status-read strobe. The status read clears every sticky bit. The data-available bit is not sticky: it follows the buffer's fill state directly.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `line_status` is all zeros.
- R2: The buffer holds up to DEPTH (default 16) bytes in arrival order. `rd_data` shows the oldest byte. A cycle with `rd_pop` high and the buffer non-empty removes that byte. `full` is 1 exactly when DEPTH bytes are held. A pop while empty has no effect.
- R3: A `wr_valid` pulse while `full` is 1 drops the character, even if `rd_pop` is high in the same cycle. The contents stay unchanged and `line_status[1]` (overrun) is set one cycle later.
- R4: `line_status[2]` (parity), `line_status[3]` (framing) and `line_status[4]` (break) are set on the clock edge at which a byte carrying that tag becomes the oldest entry. A tagged byte queued behind older bytes does not set them on arrival.
- R5: Once set, `line_status[4:1]` hold without a status read, including after the tagged byte is popped.
- R6: A cycle with `rd_stat` high clears `line_status[4:1]` at the next edge. A flag-setting event in the same cycle takes priority, and its bit stays set.
- R7: `line_status[0]` (data available) equals the inverse of `empty` at all times and is not affected by `rd_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle pulse: a complete character is available from the front end |
| wr_data | input | 8 | Received character |
| wr_par_err | input | 1 | Parity error tag for the character |
| wr_frm_err | input | 1 | Framing error tag for the character |
| wr_brk | input | 1 | Break tag for the character |
| rd_pop | input | 1 | Host data-read strobe; removes the oldest byte |
| rd_stat | input | 1 | Host status-read strobe; clears sticky status |
| rd_data | output | 8 | Oldest byte in the buffer |
| full | output | 1 | Buffer holds DEPTH bytes |
| empty | output | 1 | Buffer holds no bytes |
| line_status | output | 5 | {break, framing, parity, overrun, data available} |

## Verification
The assertions check five things on every cycle. The data-available bit must match `empty`, and `full` and `empty` must never both be high. A write while full must raise overrun and leave the head byte in place. The sticky bits must hold until a status read, and a clean status read must clear them. The assertions also cover the priority of a same-cycle overrun over the clear, and a tagged byte written into an empty buffer raising its flag on the next edge. Only the bench scenarios can show that tags follow their own bytes through the queue and surface when a pop exposes them. The same holds for the arrival order of data across wrap-around and for the buffer contents after dropped characters. These scenarios compare every cycle against a queue model under random fill and drain.

// File: rtl/rx_tag_fifo_pkg.sv
package rx_tag_fifo_pkg;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_tag_t;

    typedef struct packed {
        logic [7:0] data;
        rx_tag_t    tag;
    } rx_entry_t;

endpackage

// File: rtl/rx_tag_store.sv
module rx_tag_store
    import rx_tag_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_req,
    input  rx_entry_t push_entry,
    input  logic      pop_req,
    output rx_entry_t head_entry,
    output logic      full,
    output logic      empty,
    output logic      overrun_evt,
    output logic      head_arrive,
    output rx_tag_t   arrive_tag
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wr_ptr;
        logic [PW-1:0]         rd_ptr;
        logic [CW-1:0]         count;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic          push_ok, pop_ok;
    logic [PW-1:0] rd_next;

    always_comb begin
        st_d        = st_q;
        pop_ok      = pop_req && (st_q.count != '0);
        push_ok     = push_req && (st_q.count != CW'(DEPTH));
        overrun_evt = push_req && (st_q.count == CW'(DEPTH));
        rd_next     = ptr_inc(st_q.rd_ptr);
        head_arrive = 1'b0;
        arrive_tag  = '0;

        if (push_ok) begin
            st_d.mem[st_q.wr_ptr] = push_entry;
            st_d.wr_ptr           = ptr_inc(st_q.wr_ptr);
        end
        if (pop_ok) begin
            st_d.rd_ptr = rd_next;
        end
        st_d.count = st_q.count + CW'(push_ok) - CW'(pop_ok);

        // A new oldest entry appears either behind a popped byte or by a
        // write that lands in an empty (or emptying) buffer.
        if (pop_ok && (st_q.count > CW'(1))) begin
            head_arrive = 1'b1;
            arrive_tag  = st_q.mem[rd_next].tag;
        end else if (push_ok && ((st_q.count == '0) ||
                                 (pop_ok && (st_q.count == CW'(1))))) begin
            head_arrive = 1'b1;
            arrive_tag  = push_entry.tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_entry = st_q.mem[st_q.rd_ptr];
    assign full       = (st_q.count == CW'(DEPTH));
    assign empty      = (st_q.count == '0);

endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
    import rx_tag_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       overrun_evt,
    input  logic       head_arrive,
    input  rx_tag_t    arrive_tag,
    input  logic       empty,
    output logic [4:0] status
);
    typedef struct packed {
        logic    ovr;
        rx_tag_t flags;
    } stat_t;

    stat_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        if (clr) begin
            sq_d = '0;
        end
        // Set events are applied after the clear so they take priority.
        if (overrun_evt) begin
            sq_d.ovr = 1'b1;
        end
        if (head_arrive) begin
            sq_d.flags = sq_d.flags | arrive_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign status = {sq_q.flags.brk, sq_q.flags.frm, sq_q.flags.par,
                     sq_q.ovr, ~empty};

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import rx_tag_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic       wr_par_err,
    input  logic       wr_frm_err,
    input  logic       wr_brk,
    input  logic       rd_pop,
    input  logic       rd_stat,
    output logic [7:0] rd_data,
    output logic       full,
    output logic       empty,
    output logic [4:0] line_status
);
    rx_entry_t in_entry, head_entry;
    rx_tag_t   arrive_tag;
    logic      overrun_evt, head_arrive;

    assign in_entry.data    = wr_data;
    assign in_entry.tag.brk = wr_brk;
    assign in_entry.tag.frm = wr_frm_err;
    assign in_entry.tag.par = wr_par_err;

    rx_tag_store #(.DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_req    (wr_valid),
        .push_entry  (in_entry),
        .pop_req     (rd_pop),
        .head_entry  (head_entry),
        .full        (full),
        .empty       (empty),
        .overrun_evt (overrun_evt),
        .head_arrive (head_arrive),
        .arrive_tag  (arrive_tag)
    );

    rx_line_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (rd_stat),
        .overrun_evt (overrun_evt),
        .head_arrive (head_arrive),
        .arrive_tag  (arrive_tag),
        .empty       (empty),
        .status      (line_status)
    );

    assign rd_data = head_entry.data;

endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic [7:0] wr_data,
    input logic       wr_par_err,
    input logic       wr_frm_err,
    input logic       wr_brk,
    input logic       rd_pop,
    input logic       rd_stat,
    input logic [7:0] rd_data,
    input logic       full,
    input logic       empty,
    input logic [4:0] line_status
);
    assert_full_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_overrun_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full) |=> line_status[1]);

    assert_overrun_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full && !rd_pop) |=> (full && $stable(rd_data)));

    assert_head_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && empty && wr_par_err) |=> line_status[2]);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stat |=> ((line_status[4:1] & $past(line_status[4:1])) == $past(line_status[4:1])));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !rd_pop && !(wr_valid && (empty || full))) |=> (line_status[4:1] == 4'b0));

    assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && wr_valid && full) |=> line_status[1]);

    assert_avail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_status[0] == !empty);

endmodule

bind rx_tag_fifo rx_tag_fifo_chk u_chk (.*);

// File: tb/rx_tag_fifo_tb.sv
module rx_tag_fifo_tb;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_par_err = 1'b0, wr_frm_err = 1'b0, wr_brk = 1'b0;
    logic       rd_pop = 1'b0, rd_stat = 1'b0;
    logic [7:0] rd_data;
    logic       full, empty;
    logic [4:0] line_status;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // model: entries are {data[7:0], brk, frm, par}
    logic [10:0] mq[$];
    logic        m_ovr = 1'b0;
    logic [2:0]  m_flags = '0;

    always #2 clk = ~clk;

    rx_tag_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_par_err(wr_par_err), .wr_frm_err(wr_frm_err), .wr_brk(wr_brk),
        .rd_pop(rd_pop), .rd_stat(rd_stat), .rd_data(rd_data),
        .full(full), .empty(empty), .line_status(line_status)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [5:0] model_next_status(input int oldsize, input bit pop_ok,
                                                     input bit push_ok, input bit ovr_evt,
                                                     input bit sr, input logic [2:0] head_tag);
        logic [2:0] f;
        logic       o;
        bit         arrive;
        f = sr ? 3'b0 : m_flags;
        o = (sr ? 1'b0 : m_ovr) | ovr_evt;
        arrive = (pop_ok && oldsize > 1) || (push_ok && (oldsize == 0 || (pop_ok && oldsize == 1)));
        if (arrive) f = f | head_tag;
        return {arrive, o, f, 1'b0};
    endfunction

    task automatic step(input bit wv, input logic [7:0] d, input logic [2:0] t,
                        input bit pop, input bit sr);
        int         oldsize;
        bit         pop_ok, push_ok, ovr_evt;
        logic [5:0] ns;
        @(negedge clk);
        wr_valid = wv; wr_data = d;
        wr_brk = t[2]; wr_frm_err = t[1]; wr_par_err = t[0];
        rd_pop = pop; rd_stat = sr;
        oldsize = mq.size();
        pop_ok  = pop && oldsize > 0;
        push_ok = wv && oldsize < DEPTH;
        ovr_evt = wv && oldsize == DEPTH;
        if (pop_ok) void'(mq.pop_front());
        if (push_ok) mq.push_back({d, t});
        ns = model_next_status(oldsize, pop_ok, push_ok, ovr_evt, sr,
                               (mq.size() > 0) ? mq[0][2:0] : 3'b0);
        m_ovr = ns[4];
        m_flags = ns[3:1];
        @(posedge clk);
        #1;
        chk("R2 full", full, mq.size() == DEPTH);
        chk("R2 empty", empty, mq.size() == 0);
        if (mq.size() > 0) chk("R2 head data", rd_data, mq[0][10:3]);
        chk("R3 overrun bit", line_status[1], m_ovr);
        chk("R4 tag bits", line_status[4:2], m_flags);
        chk("R7 data available", line_status[0], mq.size() > 0);
        wr_valid = 1'b0; rd_pop = 1'b0; rd_stat = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 empty after reset", empty, 1);
        chk("R1 full after reset", full, 0);
        chk("R1 status after reset", line_status, 5'b0);

        // parity-tagged byte into empty buffer: flag shows next edge
        step(1, 8'h5A, 3'b001, 0, 0);
        chk("R4 parity on head", line_status[2], 1);
        step(0, 8'h00, 3'b000, 1, 0);
        step(0, 8'h00, 3'b000, 0, 0);
        chk("R5 parity kept after pop", line_status[2], 1);
        step(0, 8'h00, 3'b000, 0, 1);
        chk("R6 cleared by status read", line_status[4:1], 4'b0);

        // framing-tagged byte behind a clean one
        step(1, 8'h11, 3'b000, 0, 0);
        step(1, 8'h22, 3'b010, 0, 0);
        chk("R4 no framing on arrival behind", line_status[3], 0);
        step(0, 8'h00, 3'b000, 1, 0);
        chk("R4 framing when head", line_status[3], 1);
        chk("R4 head data", rd_data, 8'h22);
        step(0, 8'h00, 3'b000, 1, 1);

        // fill to full, then overrun
        for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h40 + i), 3'b000, 0, 0);
        chk("R2 full after DEPTH writes", full, 1);
        step(1, 8'hEE, 3'b100, 0, 0);
        chk("R3 overrun set", line_status[1], 1);
        chk("R3 head unchanged", rd_data, 8'h40);
        step(1, 8'hEF, 3'b100, 1, 1);
        chk("R6 overrun event wins over clear", line_status[1], 1);
        chk("R7 status read keeps available", line_status[0], 1);
        for (int i = 0; i < DEPTH + 2; i++) step(0, 8'h00, 3'b000, 1, 0);
        chk("R2 empty after drain", empty, 1);
        step(0, 8'h00, 3'b000, 0, 1);

        // random fill and drain phases
        for (int ph = 0; ph < 10; ph++) begin
            for (int c = 0; c < 400; c++) begin
                bit         wv, pp, sr;
                logic [2:0] t;
                wv = ($urandom_range(99) < ((ph % 2 == 0) ? 80 : 30));
                pp = ($urandom_range(99) < ((ph % 2 == 0) ? 30 : 80));
                sr = ($urandom_range(99) < 10);
                t  = {($urandom_range(99) < 15), ($urandom_range(99) < 15), ($urandom_range(99) < 15)};
                step(wv, 8'($urandom), t, pp, sr);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule